// File: doc/BRIEF.md
# Memory-Side Atomic Operation Adapter

This block sits between the data port of a small processor and a simple single-ported memory. The processor never executes atomic instructions itself. It sends them out as ordinary requests that carry a four-bit operation code, and the adapter performs them against memory. A read-modify-write becomes one downstream read, a combine step in an internal arithmetic unit, and one downstream write. The old word goes back to the requester as load data.

Load-reserved and store-conditional use one reservation flip-flop. That flip-flop reserves the whole address space, whatever address the load-reserved used. The adapter must be the only master of the downstream memory, and nothing upstream may cache data. With those two conditions, no other access can land between the read and write phases of an atomic. Only one operation is accepted at a time.

The sequencer has six states:

- **IDLE** grants and decodes a request.
- **RD_ISSUE** presents a downstream read until it is granted.
- **RD_WAIT** waits for read data. From there it goes either to REPLY (plain read or load-reserved) or to WR_ISSUE (read-modify-write, with the combined word latched).
- **WR_ISSUE** presents a downstream write until it is granted.
- **WR_WAIT** waits for the write acknowledge.
- **REPLY** drives a one-cycle response and returns to IDLE.

IDLE leaves for one of three states:

- REPLY, for an error or a failed store-conditional.
- WR_ISSUE, for a plain write or a successful store-conditional.
- RD_ISSUE, for everything else.

Top module: `atomic_mem_adapter`

## Requirements
- R1: Operation code 0 performs a downstream read at the request address with the request byte enables and returns the memory word. Code 1 performs a downstream write of the write data with the request byte enables and returns 0. Neither code has an alignment restriction. A downstream request holds its address and direction until granted.
- R2: Operation codes 13, 14 and 15 return an error response (err high, data 0) and cause no downstream transaction.
- R3: Codes 4 (swap), 5 (add), 6 (xor), 7 (and) and 8 (or) each return the old memory word and store the old word combined with the request write data. Each makes exactly one downstream read followed by one downstream write.
- R4: Codes 9 (min) and 10 (max) compare old word and operand as signed 32-bit values. Codes 11 (minu) and 12 (maxu) compare them as unsigned values. The selected word is stored and the old word is returned.
- R5: An operation with code 2 to 12 whose address has non-zero low two bits, or whose byte enables are not all ones, returns an error and causes no downstream transaction. Such a store-conditional still clears the reservation.
- R6: Code 2 (load-reserved) reads and returns the word and sets the reservation flag. The flag then covers every address.
- R7: Plain reads and writes leave the reservation flag unchanged.
- R8: Code 3 (store-conditional) with the flag set writes the word with one downstream write, returns 0 and clears the flag.
- R9: Code 3 with the flag clear returns 1 and causes no downstream transaction.
- R10: Once a request is accepted, gnt stays low until its single-cycle response has been delivered.
- R11: After reset, gnt is high, rvalid and the downstream request are low, and the reservation flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Upstream request valid |
| gnt_o | output | 1 | Upstream request accepted this cycle |
| addr_i | input | 32 | Byte address |
| op_i | input | 4 | Operation code |
| wdata_i | input | 32 | Write data or atomic operand |
| be_i | input | 4 | Byte enables |
| rvalid_o | output | 1 | Response valid (one cycle) |
| rdata_o | output | 32 | Response data |
| err_o | output | 1 | Response error flag |
| mem_req_o | output | 1 | Downstream request |
| mem_gnt_i | input | 1 | Downstream grant |
| mem_we_o | output | 1 | Downstream write enable |
| mem_addr_o | output | 32 | Downstream address |
| mem_wdata_o | output | 32 | Downstream write data |
| mem_be_o | output | 4 | Downstream byte enables |
| mem_rvalid_i | input | 1 | Downstream response valid |
| mem_rdata_i | input | 32 | Downstream read data |

## Verification

**Checked by the assertions on every cycle:**
- The grant stays low after an acceptance.
- Responses last exactly one cycle.
- Downstream requests hold steady until granted.
- Unknown codes never reach memory.
- Store-conditional always leaves the reservation clear.
- Plain accesses leave the reservation untouched.

**Shown only by the bench scenarios:** the data-dependent results. These are the combined value of each read-modify-write, the signed versus unsigned selection for min and max, the success or failure of a store-conditional after various mixes of accesses, and the absence of memory traffic for rejected requests. The bench checks them against a shadow memory and a shadow reservation bit.

// File: rtl/amo_adapter_pkg.sv
package amo_adapter_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_READ  = 4'd0,
        OP_WRITE = 4'd1,
        OP_LR    = 4'd2,
        OP_SC    = 4'd3,
        OP_SWAP  = 4'd4,
        OP_ADD   = 4'd5,
        OP_XOR   = 4'd6,
        OP_AND   = 4'd7,
        OP_OR    = 4'd8,
        OP_MIN   = 4'd9,
        OP_MAX   = 4'd10,
        OP_MINU  = 4'd11,
        OP_MAXU  = 4'd12
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_ISSUE,
        S_RD_WAIT,
        S_WR_ISSUE,
        S_WR_WAIT,
        S_REPLY
    } seq_state_e;

    function automatic logic op_known(input logic [OP_W-1:0] op);
        return op <= OP_MAXU;
    endfunction

    // codes that demand a full aligned word
    function automatic logic op_word_only(input logic [OP_W-1:0] op);
        return (op >= OP_LR) && (op <= OP_MAXU);
    endfunction

    function automatic logic op_rmw(input logic [OP_W-1:0] op);
        return (op >= OP_SWAP) && (op <= OP_MAXU);
    endfunction

endpackage

// File: rtl/amo_alu.sv
module amo_alu
    import amo_adapter_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] old_i,
    input  logic [DATA_W-1:0] opnd_i,
    output logic [DATA_W-1:0] res_o
);

    logic s_less;
    logic u_less;

    assign s_less = $signed(old_i) < $signed(opnd_i);
    assign u_less = old_i < opnd_i;

    always_comb begin
        res_o = old_i;
        unique case (op_i)
            OP_SWAP: res_o = opnd_i;
            OP_ADD:  res_o = old_i + opnd_i;
            OP_XOR:  res_o = old_i ^ opnd_i;
            OP_AND:  res_o = old_i & opnd_i;
            OP_OR:   res_o = old_i | opnd_i;
            OP_MIN:  res_o = s_less ? old_i : opnd_i;
            OP_MAX:  res_o = s_less ? opnd_i : old_i;
            OP_MINU: res_o = u_less ? old_i : opnd_i;
            OP_MAXU: res_o = u_less ? opnd_i : old_i;
            default: res_o = old_i;
        endcase
    end

endmodule

// File: rtl/amo_rsv.sv
module amo_rsv (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            flag_q <= 1'b0;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end
    end

    assign flag_o = flag_q;

    AST_SET_CLR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni) !(set_i && clr_i)); // R8

endmodule

// File: rtl/amo_seq.sv
module amo_seq
    import amo_adapter_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BE_W   = DATA_W / 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    output logic              gnt_o,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [BE_W-1:0]   be_i,
    output logic              rvalid_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              err_o,
    output logic              m_req_o,
    input  logic              m_gnt_i,
    output logic              m_we_o,
    output logic [ADDR_W-1:0] m_addr_o,
    output logic [DATA_W-1:0] m_wdata_o,
    output logic [BE_W-1:0]   m_be_o,
    input  logic              m_rvalid_i,
    input  logic [DATA_W-1:0] m_rdata_i,
    input  logic              rsv_flag_i,
    output logic              rsv_set_o,
    output logic              rsv_clr_o,
    output logic [OP_W-1:0]   alu_op_o,
    output logic [DATA_W-1:0] alu_opnd_o,
    input  logic [DATA_W-1:0] alu_res_i
);

    localparam int OFF_W = $clog2(BE_W);

    seq_state_e        state_q, state_d;
    logic [OP_W-1:0]   op_q, op_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [DATA_W-1:0] opnd_q, opnd_d;
    logic [BE_W-1:0]   be_q, be_d;
    logic [DATA_W-1:0] wr_q, wr_d;
    logic [DATA_W-1:0] rsp_q, rsp_d;
    logic              rerr_q, rerr_d;
    logic              misaligned;

    assign misaligned = op_word_only(op_i) &&
                        ((addr_i[OFF_W-1:0] != '0) || (be_i != '1));

    // next state and datapath
    always_comb begin
        state_d   = state_q;
        op_d      = op_q;
        addr_d    = addr_q;
        opnd_d    = opnd_q;
        be_d      = be_q;
        wr_d      = wr_q;
        rsp_d     = rsp_q;
        rerr_d    = rerr_q;
        rsv_set_o = 1'b0;
        rsv_clr_o = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (req_i) begin
                    op_d   = op_i;
                    addr_d = addr_i;
                    opnd_d = wdata_i;
                    be_d   = be_i;
                    rsp_d  = '0;
                    rerr_d = 1'b0;
                    if (!op_known(op_i) || misaligned) begin
                        rerr_d    = 1'b1;
                        rsv_clr_o = (op_i == OP_SC);
                        state_d   = S_REPLY;
                    end else if (op_i == OP_WRITE) begin
                        wr_d    = wdata_i;
                        state_d = S_WR_ISSUE;
                    end else if (op_i == OP_SC) begin
                        rsv_clr_o = 1'b1;
                        if (rsv_flag_i) begin
                            wr_d    = wdata_i;
                            state_d = S_WR_ISSUE;
                        end else begin
                            rsp_d   = DATA_W'(1);
                            state_d = S_REPLY;
                        end
                    end else begin
                        rsv_set_o = (op_i == OP_LR);
                        state_d   = S_RD_ISSUE;
                    end
                end
            end
            S_RD_ISSUE: if (m_gnt_i) state_d = S_RD_WAIT;
            S_RD_WAIT: begin
                if (m_rvalid_i) begin
                    rsp_d = m_rdata_i;
                    if (op_rmw(op_q)) begin
                        wr_d    = alu_res_i;
                        state_d = S_WR_ISSUE;
                    end else begin
                        state_d = S_REPLY;
                    end
                end
            end
            S_WR_ISSUE: if (m_gnt_i) state_d = S_WR_WAIT;
            S_WR_WAIT:  if (m_rvalid_i) state_d = S_REPLY;
            S_REPLY:    state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= S_IDLE;
            op_q    <= '0;
            addr_q  <= '0;
            opnd_q  <= '0;
            be_q    <= '0;
            wr_q    <= '0;
            rsp_q   <= '0;
            rerr_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            op_q    <= op_d;
            addr_q  <= addr_d;
            opnd_q  <= opnd_d;
            be_q    <= be_d;
            wr_q    <= wr_d;
            rsp_q   <= rsp_d;
            rerr_q  <= rerr_d;
        end
    end

    // outputs
    always_comb begin
        gnt_o      = (state_q == S_IDLE);
        m_req_o    = (state_q == S_RD_ISSUE) || (state_q == S_WR_ISSUE);
        m_we_o     = (state_q == S_WR_ISSUE);
        m_addr_o   = addr_q;
        m_wdata_o  = wr_q;
        m_be_o     = be_q;
        rvalid_o   = (state_q == S_REPLY);
        rdata_o    = rsp_q;
        err_o      = rerr_q;
        alu_op_o   = op_q;
        alu_opnd_o = opnd_q;
    end

    AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni) (req_i && gnt_o) |=> !gnt_o); // R10
    AST_RVALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni) rvalid_o |=> !rvalid_o); // R10
    AST_DN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) (m_req_o && !m_gnt_i) |=> (m_req_o && $stable(m_addr_o) && $stable(m_we_o))); // R1
    AST_BAD_OP_NO_DN: assert property (@(posedge clk_i) disable iff (!rst_ni) (req_i && gnt_o && (op_i > OP_MAXU)) |=> !m_req_o); // R2
    AST_SC_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni) (req_i && gnt_o && (op_i == OP_SC)) |=> !rsv_flag_i); // R8
    AST_PLAIN_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni) (req_i && gnt_o && (op_i <= OP_WRITE)) |=> $stable(rsv_flag_i)); // R7

endmodule

// File: rtl/atomic_mem_adapter.sv
module atomic_mem_adapter
    import amo_adapter_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BE_W   = DATA_W / 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    output logic              gnt_o,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [BE_W-1:0]   be_i,
    output logic              rvalid_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              err_o,
    output logic              mem_req_o,
    input  logic              mem_gnt_i,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic [BE_W-1:0]   mem_be_o,
    input  logic              mem_rvalid_i,
    input  logic [DATA_W-1:0] mem_rdata_i
);

    logic              rsv_flag;
    logic              rsv_set;
    logic              rsv_clr;
    logic [OP_W-1:0]   alu_op;
    logic [DATA_W-1:0] alu_opnd;
    logic [DATA_W-1:0] alu_res;

    amo_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BE_W   (BE_W)
    ) u_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .req_i      (req_i),
        .gnt_o      (gnt_o),
        .addr_i     (addr_i),
        .op_i       (op_i),
        .wdata_i    (wdata_i),
        .be_i       (be_i),
        .rvalid_o   (rvalid_o),
        .rdata_o    (rdata_o),
        .err_o      (err_o),
        .m_req_o    (mem_req_o),
        .m_gnt_i    (mem_gnt_i),
        .m_we_o     (mem_we_o),
        .m_addr_o   (mem_addr_o),
        .m_wdata_o  (mem_wdata_o),
        .m_be_o     (mem_be_o),
        .m_rvalid_i (mem_rvalid_i),
        .m_rdata_i  (mem_rdata_i),
        .rsv_flag_i (rsv_flag),
        .rsv_set_o  (rsv_set),
        .rsv_clr_o  (rsv_clr),
        .alu_op_o   (alu_op),
        .alu_opnd_o (alu_opnd),
        .alu_res_i  (alu_res)
    );

    amo_rsv u_rsv (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (rsv_set),
        .clr_i  (rsv_clr),
        .flag_o (rsv_flag)
    );

    amo_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .op_i   (alu_op),
        .old_i  (mem_rdata_i),
        .opnd_i (alu_opnd),
        .res_o  (alu_res)
    );

endmodule

// File: tb/test_atomic_mem_adapter.sv
module test_atomic_mem_adapter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        gnt;
    logic [31:0] addr = '0;
    logic [3:0]  op = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  be = '0;
    logic        rvalid;
    logic [31:0] rdata;
    logic        err;
    logic        m_req;
    logic        m_gnt;
    logic        m_we;
    logic [31:0] m_addr;
    logic [31:0] m_wdata;
    logic [3:0]  m_be;
    logic        m_rvalid = 1'b0;
    logic [31:0] m_rdata = '0;
    logic        gnt_roll = 1'b1;

    logic [31:0] dmem    [16];
    logic [31:0] exp_mem [16];
    logic        exp_flag;
    int          ntx = 0;
    int          errors = 0;
    int          checks = 0;
    int          cycles = 0;

    always #10 clk = ~clk;

    atomic_mem_adapter i_atomic_mem_adapter (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .gnt_o(gnt), .addr_i(addr),
        .op_i(op), .wdata_i(wdata), .be_i(be), .rvalid_o(rvalid), .rdata_o(rdata),
        .err_o(err), .mem_req_o(m_req), .mem_gnt_i(m_gnt), .mem_we_o(m_we),
        .mem_addr_o(m_addr), .mem_wdata_o(m_wdata), .mem_be_o(m_be),
        .mem_rvalid_i(m_rvalid), .mem_rdata_i(m_rdata)
    );

    assign m_gnt = gnt_roll;

    // downstream memory with random grant stalls
    always @(posedge clk) begin
        cycles <= cycles + 1;
        m_rvalid <= 1'b0;
        gnt_roll <= ($urandom_range(0, 3) != 0);
        if (rst_n && m_req && m_gnt) begin
            ntx <= ntx + 1;
            if (m_we) begin
                for (int b = 0; b < 4; b++)
                    if (m_be[b]) dmem[m_addr[5:2]][8*b +: 8] <= m_wdata[8*b +: 8];
            end else begin
                m_rdata <= dmem[m_addr[5:2]];
            end
            m_rvalid <= 1'b1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_amo(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b);
        case (c)
            4'd4:    return b;
            4'd5:    return a + b;
            4'd6:    return a ^ b;
            4'd7:    return a & b;
            4'd8:    return a | b;
            4'd9:    return ($signed(a) <= $signed(b)) ? a : b;
            4'd10:   return ($signed(a) >= $signed(b)) ? a : b;
            4'd11:   return (a <= b) ? a : b;
            default: return (a >= b) ? a : b;
        endcase
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] m);
        logic [31:0] r = o;
        for (int b = 0; b < 4; b++) if (m[b]) r[8*b +: 8] = n[8*b +: 8];
        return r;
    endfunction

    task automatic run_op(input logic [3:0] c, input int idx, input logic [1:0] off,
                          input logic [31:0] wd, input logic [3:0] m);
        int          tx0;
        logic [31:0] got;
        logic        gerr;
        logic [31:0] e_data;
        logic        e_err;
        int          e_tx;
        string       tag;
        @(negedge clk);
        req = 1'b1; op = c; addr = {26'd0, idx[3:0], off}; wdata = wd; be = m;
        while (!gnt) @(negedge clk);
        tx0 = ntx;
        @(negedge clk);
        req = 1'b0;
        while (!rvalid) begin
            if (gnt) begin
                errors++; checks++;
                $display("FAIL R10: actual gnt=1 expected gnt=0 while busy");
            end
            @(negedge clk);
        end
        got = rdata; gerr = err;
        @(negedge clk);
        // expected outcome
        e_data = '0; e_err = 1'b0; e_tx = 0;
        if (c > 4'd12) begin
            tag = "R2"; e_err = 1'b1;
        end else if (c >= 4'd2 && (off != 2'b00 || m != 4'hF)) begin
            tag = "R5"; e_err = 1'b1;
            if (c == 4'd3) exp_flag = 1'b0;
        end else if (c == 4'd0) begin
            tag = "R1"; e_data = exp_mem[idx]; e_tx = 1;
        end else if (c == 4'd1) begin
            tag = "R1"; exp_mem[idx] = merge(exp_mem[idx], wd, m); e_tx = 1;
        end else if (c == 4'd2) begin
            tag = "R6"; e_data = exp_mem[idx]; e_tx = 1; exp_flag = 1'b1;
        end else if (c == 4'd3) begin
            if (exp_flag) begin
                tag = "R8"; exp_mem[idx] = wd; e_tx = 1;
            end else begin
                tag = "R9"; e_data = 32'd1;
            end
            exp_flag = 1'b0;
        end else begin
            tag = (c >= 4'd9) ? "R4" : "R3";
            e_data = exp_mem[idx];
            exp_mem[idx] = ref_amo(c, exp_mem[idx], wd);
            e_tx = 2;
        end
        chk({tag, " rdata"}, got, e_data);
        chk({tag, " err"}, {31'd0, gerr}, {31'd0, e_err});
        chk({tag, " downstream count"}, ntx - tx0, e_tx);
        chk({tag, " memory word"}, dmem[idx], exp_mem[idx]);
    endtask

    initial begin
        void'($urandom(32'd20240607));
        for (int i = 0; i < 16; i++) begin
            dmem[i] = $urandom();
            exp_mem[i] = dmem[i];
        end
        exp_flag = 1'b0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 gnt", {31'd0, gnt}, 32'd1);
        chk("R11 rvalid", {31'd0, rvalid}, 32'd0);
        chk("R11 mem_req", {31'd0, m_req}, 32'd0);
        rst_n = 1'b1;
        // R11/R9: no reservation right after reset
        run_op(4'd3, 3, 2'b00, 32'hDEAD_BEEF, 4'hF);
        // R1 plain traffic with partial enables and odd offsets
        run_op(4'd1, 5, 2'b01, 32'h1122_3344, 4'b0101);
        run_op(4'd0, 5, 2'b10, 32'h0, 4'b0011);
        // R6 and R7: reservation from one address, plain accesses, SC elsewhere succeeds
        run_op(4'd2, 1, 2'b00, 32'h0, 4'hF);
        run_op(4'd0, 2, 2'b00, 32'h0, 4'hF);
        run_op(4'd1, 4, 2'b00, 32'h5555_AAAA, 4'hF);
        run_op(4'd3, 9, 2'b00, 32'hCAFE_F00D, 4'hF);
        run_op(4'd3, 9, 2'b00, 32'h0BAD_0BAD, 4'hF);
        // R2 unknown codes
        run_op(4'd13, 0, 2'b00, 32'h1, 4'hF);
        run_op(4'd15, 0, 2'b00, 32'h1, 4'hF);
        // R5 misaligned / partial atomics; misaligned SC still clears
        run_op(4'd5, 6, 2'b10, 32'h7, 4'hF);
        run_op(4'd9, 6, 2'b00, 32'h7, 4'b0111);
        run_op(4'd2, 7, 2'b00, 32'h0, 4'hF);
        run_op(4'd3, 7, 2'b01, 32'h1, 4'hF);
        run_op(4'd3, 7, 2'b00, 32'h1, 4'hF);
        // R4 signed vs unsigned corners
        run_op(4'd4, 8, 2'b00, 32'hFFFF_FFFE, 4'hF);
        run_op(4'd9, 8, 2'b00, 32'h0000_0003, 4'hF);
        run_op(4'd4, 8, 2'b00, 32'h8000_0000, 4'hF);
        run_op(4'd10, 8, 2'b00, 32'h7FFF_FFFF, 4'hF);
        run_op(4'd4, 8, 2'b00, 32'hFFFF_FFFE, 4'hF);
        run_op(4'd11, 8, 2'b00, 32'h0000_0003, 4'hF);
        run_op(4'd12, 8, 2'b00, 32'h8000_0000, 4'hF);
        // R3 each logic/arith op
        for (int c = 4; c <= 8; c++) run_op(4'(c), 10, 2'b00, $urandom(), 4'hF);
        // random mix
        for (int n = 0; n < 400; n++) begin
            int          sel = $urandom_range(0, 31);
            logic [3:0]  c = (sel < 29) ? 4'($urandom_range(0, 12)) : 4'($urandom_range(13, 15));
            logic [1:0]  off = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            logic [3:0]  m = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(0, 14)) : 4'hF;
            run_op(c, $urandom_range(0, 15), off, $urandom(), m);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule